// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A requester hands it one virtual address together with the access kind (read or write) and the privilege of the access (user or supervisor) over a valid/ready handshake. The walker then reads the directory entry, and either treats it as a large 4 MB page or goes on to fetch a 4 KB table entry. It checks the access against the permission bits and returns either a translation or a page fault.

Memory is reached through a single 32-bit port with a request/acknowledge handshake, used for both reads and write-backs. The walker keeps the accessed and dirty flags of the entries it uses up to date in memory. It writes an entry back only when one of those flags actually changes. Every table address and the returned frame are ANDed with an address-bit-20 style mask input. For a large page only the 4 KB frame that holds the address is returned, so a translation cache behind the walker always sees 4 KB frames.

Only one walk is in flight at a time. The result is presented for exactly one cycle. On a fault the faulting virtual address is also latched into a held output register.

Top module: `ptw_two_level`

## Requirements
- R1: The directory entry address is `((cfg_root & ~0xFFF) + vaddr[31:22]*4) & cfg_a20_mask`. The table entry address is `((dir_entry & ~0xFFF) + vaddr[21:12]*4) & cfg_a20_mask`. No memory address leaves a bit set that the mask clears.
- R2: If an entry read at either level has bit 0 (present) clear, the walk stops with a fault whose error bit 0 is 0. No further read is issued after that entry.
- R3: A directory entry is a 4 MB leaf only when its bit 7 is set and `cfg_large_en` is high. With `cfg_large_en` low, bit 7 is ignored and the table entry is fetched.
- R4: The effective permission is the directory entry alone for a 4 MB leaf, and the AND of the directory and table entries for a 4 KB page. Bit 1 means writable and bit 2 means user-accessible. A user access faults unless user-accessible. A user write faults unless writable. A supervisor write faults when `cfg_wp` is high and the page is not writable. Such a fault sets error bit 0 to 1, and the leaf entry is not written back.
- R5: The fault error code `rsp_err` holds bit 0 = protection violation (1) or not present (0), bit 1 = the access was a write, and bit 2 = the access was a user access.
- R6: On a successful walk the leaf entry gets bit 5 (accessed) set. On a write it also gets bit 6 (dirty) set. The entry is written back only if that changed its value.
- R7: A non-leaf directory entry with bit 5 clear is written back with bit 5 set before the table entry is read, even if the walk later faults. A non-leaf entry never gets bit 6 set.
- R8: On success, `rsp_paddr` is `({frame, 12'h000} & cfg_a20_mask) | vaddr[11:0]`. The frame is table entry bits 31:12 for a 4 KB page. For a 4 MB page it is directory entry bits 31:22 followed by vaddr bits 21:12.
- R9: On a fault, `rsp_fault_addr` takes the faulting virtual address. It holds that value through later successful walks and is zero after reset.
- R10: `req_ready` is high only when idle. It falls after a request is accepted and stays low through the single cycle in which `rsp_valid` is high. After reset `req_ready` is high, while `rsp_valid` and `mem_req` are low.
- R11: On success, `rsp_large` tells whether a 4 MB leaf was used. `rsp_rw` and `rsp_user` give the effective writable and user bits.
- R12: `mem_req` stays high with a stable address, write enable and write data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| cfg_root | input | 32 | Directory base (low 12 bits ignored) |
| cfg_large_en | input | 1 | Allow 4 MB leaf pages |
| cfg_wp | input | 1 | Enforce read-only pages on supervisor writes |
| cfg_a20_mask | input | 32 | Mask ANDed into table addresses and frames |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Entry read, valid with mem_ack |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_err | output | 3 | Fault error code |
| rsp_paddr | output | 32 | Physical address |
| rsp_large | output | 1 | Translation came from a 4 MB leaf |
| rsp_rw | output | 1 | Effective writable bit |
| rsp_user | output | 1 | Effective user bit |
| rsp_fault_addr | output | 32 | Last faulting virtual address |

## Verification
The bench sweeps all sixteen combinations of directory and table permission bits against every access kind and both write-protect settings. It repeats the sweep in three page modes: plain table walk, enabled large leaf, and large-page bit set but disabled. The accessed, dirty and present flags rotate through the runs. It counts reads and write-backs per walk. A design that always wrote entries back, set dirty on a non-leaf directory entry, or skipped the accessed update before a table fault would show the wrong write count or memory contents. A design that honoured bit 7 without the enable would issue one read instead of two. A final group of walks runs with a mask that clears address bit 13. This catches a mask left off the table addresses or the frame, and a large page that returns the whole 4 MB base instead of the 4 KB slice.

// File: rtl/ptw_pkg.sv
// Package: shared entry bit positions, error code bits and walker state type.
// Assumes 32-bit entries with flags in the low byte.
package ptw_pkg;

    localparam int ENT_PRESENT  = 0;
    localparam int ENT_WRITABLE = 1;
    localparam int ENT_USER     = 2;
    localparam int ENT_ACCESSED = 5;
    localparam int ENT_DIRTY    = 6;
    localparam int ENT_LARGE    = 7;

    localparam int ERR_BITS     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB,
        ST_DONE
    } walk_state_t;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: forms an entry address from a table base and an index.
// The base is page aligned by dropping its low bits, the index is scaled by
// the entry size, and the sum is ANDed with the supplied mask.
module ptw_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10,
    parameter int ENTRY_LG   = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  index_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - IDX_W - ENTRY_LG;

    logic [ADDR_W-1:0] base_aligned;
    logic [ADDR_W-1:0] index_bytes;
    logic              unused_base_low;

    // drop the in-page bits of the base
    assign base_aligned    = {base_i[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    // scale the index to a byte offset
    assign index_bytes     = {{PAD_W{1'b0}}, index_i, {ENTRY_LG{1'b0}}};
    // masked sum is the entry address
    assign addr_o          = (base_aligned + index_bytes) & mask_i;
    assign unused_base_low = ^base_i[PAGE_SHIFT-1:0];

endmodule

// File: rtl/ptw_perm_check.sv
// Module: decides whether an access violates the effective page permission.
// Assumes the caller has already combined the levels into one writable and
// one user bit.
module ptw_perm_check (
    input  logic eff_rw_i,
    input  logic eff_user_i,
    input  logic is_write_i,
    input  logic is_user_i,
    input  logic wp_en_i,
    output logic violate_o
);
    // user accesses need the user bit, writes need writable unless a
    // supervisor write with protection disabled
    always_comb begin
        if (is_user_i) begin
            violate_o = !eff_user_i || (is_write_i && !eff_rw_i);
        end else begin
            violate_o = wp_en_i && is_write_i && !eff_rw_i;
        end
    end

endmodule

// File: rtl/ptw_flag_update.sv
// Module: computes the entry value after the accessed/dirty update and
// whether it differs from the value read, so a write-back can be skipped.
module ptw_flag_update #(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic               set_dirty_i,
    output logic [ENTRY_W-1:0] entry_o,
    output logic               changed_o
);
    import ptw_pkg::*;

    // accessed always, dirty only when asked
    always_comb begin
        entry_o               = entry_i;
        entry_o[ENT_ACCESSED] = 1'b1;
        if (set_dirty_i) begin
            entry_o[ENT_DIRTY] = 1'b1;
        end
        changed_o = (entry_o != entry_i);
    end

endmodule

// File: rtl/ptw_two_level.sv
// Module: sequential two-level page table walker.
// Accepts one translation at a time, reads the directory entry and, unless it
// is an enabled large leaf, the table entry; checks permissions, updates the
// accessed/dirty flags in memory when they change and presents the result for
// one cycle. Assumes cfg_* inputs stay stable while a walk is in flight and
// that ADDR_W == PAGE_SHIFT + 2*IDX_W.
module ptw_two_level #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] cfg_root,
    input  logic              cfg_large_en,
    input  logic              cfg_wp,
    input  logic [ADDR_W-1:0] cfg_a20_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_err,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_large,
    output logic              rsp_rw,
    output logic              rsp_user,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    import ptw_pkg::*;

    localparam int FRAME_W     = ADDR_W - PAGE_SHIFT;
    localparam int LARGE_SHIFT = PAGE_SHIFT + IDX_W;
    localparam int DIR_IDX_W   = ADDR_W - LARGE_SHIFT;
    localparam int SLICE_W     = LARGE_SHIFT - PAGE_SHIFT;

    walk_state_t         state;
    logic [ADDR_W-1:0]   va_q;
    logic                wr_q;
    logic                usr_q;
    logic [FRAME_W-1:0]  dir_frame_q;
    logic                dir_rw_q;
    logic                dir_us_q;
    logic                leaf_wb_q;
    logic [ADDR_W-1:0]   wb_q;

    logic                res_fault_q;
    logic [ERR_BITS-1:0] res_err_q;
    logic [FRAME_W-1:0]  res_frame_q;
    logic                res_large_q;
    logic                res_rw_q;
    logic                res_us_q;
    logic [ADDR_W-1:0]   fault_addr_q;

    logic [ADDR_W-1:0]   dir_addr;
    logic [ADDR_W-1:0]   tbl_addr;
    logic                in_tbl;
    logic                dir_is_leaf;
    logic                eff_rw;
    logic                eff_us;
    logic                violate;
    logic                set_dirty;
    logic [ADDR_W-1:0]   upd_entry;
    logic                upd_changed;
    logic [FRAME_W-1:0]  large_frame;
    logic [FRAME_W-1:0]  small_frame;
    logic [FRAME_W-1:0]  frame_mask;

    // directory entry address from the root and the top index bits
    ptw_addr_gen #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(DIR_IDX_W), .ENTRY_LG(2)
    ) u_dir_addr (
        .base_i (cfg_root),
        .index_i(va_q[ADDR_W-1:LARGE_SHIFT]),
        .mask_i (cfg_a20_mask),
        .addr_o (dir_addr)
    );

    // table entry address from the stored directory frame and middle index
    ptw_addr_gen #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(SLICE_W), .ENTRY_LG(2)
    ) u_tbl_addr (
        .base_i ({dir_frame_q, {PAGE_SHIFT{1'b0}}}),
        .index_i(va_q[LARGE_SHIFT-1:PAGE_SHIFT]),
        .mask_i (cfg_a20_mask),
        .addr_o (tbl_addr)
    );

    // effective permission: directory alone, or both levels ANDed
    assign in_tbl      = (state == ST_TBL_RD);
    assign dir_is_leaf = mem_rdata[ENT_LARGE] && cfg_large_en;
    assign eff_rw      = in_tbl ? (dir_rw_q & mem_rdata[ENT_WRITABLE]) : mem_rdata[ENT_WRITABLE];
    assign eff_us      = in_tbl ? (dir_us_q & mem_rdata[ENT_USER])     : mem_rdata[ENT_USER];

    ptw_perm_check u_perm (
        .eff_rw_i  (eff_rw),
        .eff_user_i(eff_us),
        .is_write_i(wr_q),
        .is_user_i (usr_q),
        .wp_en_i   (cfg_wp),
        .violate_o (violate)
    );

    // dirty is only set on a leaf; a pointer entry only gains accessed
    assign set_dirty = wr_q && (in_tbl || dir_is_leaf);

    ptw_flag_update #(.ENTRY_W(ADDR_W)) u_flags (
        .entry_i    (mem_rdata),
        .set_dirty_i(set_dirty),
        .entry_o    (upd_entry),
        .changed_o  (upd_changed)
    );

    // candidate frames and the mask applied to them
    assign large_frame = {mem_rdata[ADDR_W-1:LARGE_SHIFT], va_q[LARGE_SHIFT-1:PAGE_SHIFT]};
    assign small_frame = mem_rdata[ADDR_W-1:PAGE_SHIFT];
    assign frame_mask  = cfg_a20_mask[ADDR_W-1:PAGE_SHIFT];

    // walk sequencing, result capture and fault address latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            va_q         <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            dir_frame_q  <= '0;
            dir_rw_q     <= 1'b0;
            dir_us_q     <= 1'b0;
            leaf_wb_q    <= 1'b0;
            wb_q         <= '0;
            res_fault_q  <= 1'b0;
            res_err_q    <= '0;
            res_frame_q  <= '0;
            res_large_q  <= 1'b0;
            res_rw_q     <= 1'b0;
            res_us_q     <= 1'b0;
            fault_addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_vaddr;
                        wr_q  <= req_write;
                        usr_q <= req_user;
                        state <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        dir_frame_q <= mem_rdata[ADDR_W-1:PAGE_SHIFT];
                        dir_rw_q    <= mem_rdata[ENT_WRITABLE];
                        dir_us_q    <= mem_rdata[ENT_USER];
                        wb_q        <= upd_entry;
                        leaf_wb_q   <= dir_is_leaf;
                        if (!mem_rdata[ENT_PRESENT] || (dir_is_leaf && violate)) begin
                            res_fault_q  <= 1'b1;
                            res_err_q    <= {usr_q, wr_q, mem_rdata[ENT_PRESENT]};
                            fault_addr_q <= va_q;
                            state        <= ST_DONE;
                        end else if (dir_is_leaf) begin
                            res_fault_q <= 1'b0;
                            res_frame_q <= large_frame & frame_mask;
                            res_large_q <= 1'b1;
                            res_rw_q    <= eff_rw;
                            res_us_q    <= eff_us;
                            state       <= upd_changed ? ST_DIR_WB : ST_DONE;
                        end else begin
                            state <= upd_changed ? ST_DIR_WB : ST_TBL_RD;
                        end
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ack) begin
                        state <= leaf_wb_q ? ST_DONE : ST_TBL_RD;
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        wb_q <= upd_entry;
                        if (!mem_rdata[ENT_PRESENT] || violate) begin
                            res_fault_q  <= 1'b1;
                            res_err_q    <= {usr_q, wr_q, mem_rdata[ENT_PRESENT]};
                            fault_addr_q <= va_q;
                            state        <= ST_DONE;
                        end else begin
                            res_fault_q <= 1'b0;
                            res_frame_q <= small_frame & frame_mask;
                            res_large_q <= 1'b0;
                            res_rw_q    <= eff_rw;
                            res_us_q    <= eff_us;
                            state       <= upd_changed ? ST_TBL_WB : ST_DONE;
                        end
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // handshake and memory port outputs decoded from the state
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_DONE);
    assign mem_req   = (state == ST_DIR_RD) || (state == ST_DIR_WB) ||
                       (state == ST_TBL_RD) || (state == ST_TBL_WB);
    assign mem_we    = (state == ST_DIR_WB) || (state == ST_TBL_WB);
    assign mem_addr  = ((state == ST_DIR_RD) || (state == ST_DIR_WB)) ? dir_addr : tbl_addr;
    assign mem_wdata = wb_q;

    // held result fields
    assign rsp_fault      = res_fault_q;
    assign rsp_err        = res_err_q;
    assign rsp_paddr      = {res_frame_q, va_q[PAGE_SHIFT-1:0]};
    assign rsp_large      = res_large_q;
    assign rsp_rw         = res_rw_q;
    assign rsp_user       = res_us_q;
    assign rsp_fault_addr = fault_addr_q;

endmodule

// File: rtl/ptw_walk_checker.sv
// Module: protocol and result assertions for the walker, attached by bind.
// Tracks the accepted virtual address on its own to judge the outputs.
module ptw_walk_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [ADDR_W-1:0] cfg_a20_mask,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] rsp_fault_addr
);
    logic [ADDR_W-1:0] seen_va;

    // remember the address of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_va <= '0;
        end else if (req_valid && req_ready) begin
            seen_va <= req_vaddr;
        end
    end

    AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ~cfg_a20_mask) == '0)); // R1
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0])); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R10
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_fault_addr == seen_va)); // R9
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == seen_va[11:0])); // R8
    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

endmodule

bind ptw_two_level ptw_walk_checker #(.ADDR_W(ADDR_W)) u_walk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .cfg_a20_mask  (cfg_a20_mask),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault_addr(rsp_fault_addr)
);

// File: tb/test_ptw_two_level.sv
`timescale 1ns/1ps
// Bench: sweeps permission bits, access kinds, write protection and page
// modes, computing expected results, reads, write-backs and memory contents.
module test_ptw_two_level;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] cfg_root = 32'h0000_1000;
    logic        cfg_large_en = 1'b1;
    logic        cfg_wp = 1'b0;
    logic [31:0] cfg_a20_mask = 32'hFFFF_FFFF;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault, rsp_large, rsp_rw, rsp_user;
    logic [2:0]  rsp_err;
    logic [31:0] rsp_paddr, rsp_fault_addr;

    always #2.5 clk = ~clk;

    ptw_two_level i_ptw_two_level (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .cfg_root(cfg_root), .cfg_large_en(cfg_large_en), .cfg_wp(cfg_wp),
        .cfg_a20_mask(cfg_a20_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
        .rsp_paddr(rsp_paddr), .rsp_large(rsp_large), .rsp_rw(rsp_rw),
        .rsp_user(rsp_user), .rsp_fault_addr(rsp_fault_addr)
    );

    // memory model: 4096 words indexed by address bits 13:2, one-cycle ack
    logic [31:0] mem [4096];
    logic        tb_we = 1'b0;
    logic [11:0] tb_idx = '0;
    logic [31:0] tb_data = '0;
    logic        clr_log = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [4];

    always @(posedge clk) begin
        if (tb_we) mem[tb_idx] <= tb_data;
        if (clr_log) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] prev_fault = '0;

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mem_put(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        tb_we = 1'b1; tb_idx = addr[13:2]; tb_data = data;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [19:0] frame, input logic ps, input logic d,
                                       input logic a, input logic us, input logic rw, input logic p);
        return {frame, 4'b0, ps, d, a, 2'b0, us, rw, p};
    endfunction

    // one walk with full expected-value computation
    task automatic walk(input logic [31:0] va, input logic [31:0] de, input logic [31:0] te,
                        input logic wr, input logic us);
        logic [31:0] d_addr, t_addr, exp_de, exp_te, exp_pa, nt;
        logic [19:0] frame;
        logic        leaf, e_rw, e_us, viol, e_fault, prot, e_large;
        int          e_rd, e_wr, n;
        d_addr = ((cfg_root & 32'hFFFF_F000) + {20'b0, va[31:22], 2'b0}) & cfg_a20_mask;
        t_addr = ((de & 32'hFFFF_F000) + {20'b0, va[21:12], 2'b0}) & cfg_a20_mask;
        mem_put(d_addr, de);
        mem_put(t_addr, te);
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;

        leaf = de[7] && cfg_large_en;
        exp_de = de; exp_te = te; e_rd = 1; e_wr = 0;
        e_fault = 1'b0; prot = 1'b0; frame = '0; e_rw = 1'b0; e_us = 1'b0; e_large = 1'b0;
        if (!de[0]) begin
            e_fault = 1'b1;
        end else if (leaf) begin
            e_rw = de[1]; e_us = de[2]; e_large = 1'b1;
            viol = us ? (!e_us || (wr && !e_rw)) : (cfg_wp && wr && !e_rw);
            if (viol) begin
                e_fault = 1'b1; prot = 1'b1;
            end else begin
                nt = de | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (nt != de) begin e_wr = 1; exp_de = nt; end
                frame = {de[31:22], va[21:12]};
            end
        end else begin
            e_rd = 2;
            if (!de[5]) begin e_wr = 1; exp_de = de | 32'h20; end
            if (!te[0]) begin
                e_fault = 1'b1;
            end else begin
                e_rw = de[1] & te[1]; e_us = de[2] & te[2];
                viol = us ? (!e_us || (wr && !e_rw)) : (cfg_wp && wr && !e_rw);
                if (viol) begin
                    e_fault = 1'b1; prot = 1'b1;
                end else begin
                    nt = te | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (nt != te) begin e_wr = e_wr + 1; exp_te = nt; end
                    frame = te[31:12];
                end
            end
        end
        exp_pa = ({frame, 12'h000} & cfg_a20_mask) | {20'b0, va[11:0]};

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
        chk("R10 ready when idle", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) chk("R10 ready low while busy", 32'd1, 32'd0);
            @(negedge clk);
            n++;
        end
        chk("R10 response arrives", {31'b0, rsp_valid}, 32'd1);
        chk("R10 ready low with response", {31'b0, req_ready}, 32'd0);
        chk("R2 R4 fault flag", {31'b0, rsp_fault}, {31'b0, e_fault});
        if (e_fault) begin
            chk("R5 error code", {29'b0, rsp_err}, {29'b0, us, wr, prot});
            chk("R9 fault address latched", rsp_fault_addr, va);
            prev_fault = va;
        end else begin
            chk("R8 physical address", rsp_paddr, exp_pa);
            chk("R11 large flag", {31'b0, rsp_large}, {31'b0, e_large});
            chk("R11 effective rw/user", {30'b0, rsp_rw, rsp_user}, {30'b0, e_rw, e_us});
            chk("R9 fault address held", rsp_fault_addr, prev_fault);
        end
        chk("R2 R3 read count", rd_cnt, e_rd);
        chk("R1 directory address", rd_log[0], d_addr);
        if (e_rd == 2) chk("R1 table address", rd_log[1], t_addr);
        chk("R6 R7 write-back count", wr_cnt, e_wr);
        chk("R6 R7 directory entry in memory", mem[d_addr[13:2]], exp_de);
        chk("R4 R6 table entry in memory", mem[t_addr[13:2]], exp_te);
        @(negedge clk);
        chk("R10 response lasts one cycle", {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R10 reset no response", {31'b0, rsp_valid}, 32'd0);
        chk("R10 reset no memory request", {31'b0, mem_req}, 32'd0);
        chk("R9 reset fault address", rsp_fault_addr, 32'd0);

        // mode 0: 4 KB walk, mode 1: enabled large leaf, mode 2: large bit with R3 enable low
        for (int mode = 0; mode < 3; mode++) begin
            for (int p = 0; p < 16; p++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [2:0]  ad;
                        logic [19:0] dframe;
                        logic        dp, tp;
                        logic [31:0] de, te, va;
                        @(negedge clk);
                        cfg_wp = w[0];
                        cfg_large_en = (mode != 2);
                        ad = 3'((p * 3 + a + w * 5 + mode) % 8);
                        dp = ((p * 4 + a) % 13) != 5;
                        tp = ((p * 4 + a + w) % 11) != 7;
                        dframe = (mode == 1) ? {10'((p * 77 + a) & 10'h3FF), 10'h2AB} : 20'h5A5A6;
                        de = mk(dframe, mode != 0, ad[2], ad[0], p[1], p[0], dp);
                        te = mk({12'hC3A ^ 12'(p), 8'(a * 29 + w * 3 + mode)}, 1'b0,
                                ad[2], ad[1], p[3], p[2], tp);
                        va = {10'(mode * 131 + p * 17 + a * 5 + w), 10'(p * 37 + a * 11 + mode),
                              12'(p * 85 + a * 7 + w)};
                        walk(va, de, te, a[0], a[1]);
                    end
                end
            end
        end

        // R1 R8: mask clearing address bit 13 on root, table and frame
        @(negedge clk);
        cfg_a20_mask = 32'hFFFF_DFFF; cfg_root = 32'h0000_3000; cfg_wp = 1'b1; cfg_large_en = 1'b1;
        walk(32'h1234_5678, mk(20'h5A5A6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1),
             mk(20'hABCD2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1), 1'b1, 1'b1);
        walk(32'hFEDC_BA98, mk(20'h7FE02, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1),
             32'h0, 1'b0, 1'b0);
        walk(32'h0040_2ABC, mk(20'h5A5A6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1),
             mk(20'h00002, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1), 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule